// File: doc/BRIEF.md
# SPI Slave Transmit/Receive Streaming Sequencer

This block sits on the system-clock side of an SPI slave's parallel port. Its job is to keep the serial bus streaming words back to back. It holds two small synchronous RAMs: a transmit RAM, which the slave draws from, and a receive RAM, which the slave fills. A host loads and dumps both RAMs through a single address/data port while streaming is switched off.

Once streaming is on, each lookahead data request from the slave starts one fetch. The sequencer registers the next transmit address, lets the RAM return the word one cycle later, and then presents that word with a one-cycle write enable. The whole fetch fits inside the slave's lookahead window of three bit times.

Each received-data strobe from the slave stores the slave's parallel word at the next receive address. The slave's write acknowledge gates the next write enable. A request that arrives while a fetch is still in flight raises a sticky error flag.

Top module: `spi_stream_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `slv_tx_we_o`, `slv_tx_word_o`, `fetch_err_o` and `rx_wptr_o` are all zero.
- R2: A request is recognised only on a rising edge of `slv_req_i` (low at the previous clock edge, high at this one), and only while `stream_en_i` is 1. A two-cycle request pulse therefore yields exactly one write enable. A request while streaming is off yields none.
- R3: Call E0 the clock edge at which a new request is first sampled high with the pipeline idle and no acknowledge outstanding. `slv_tx_we_o` is then high for exactly one cycle, starting at the second edge after E0 (E0+2).
- R4: Delivered words come from transmit RAM indices 0, 1, … up to `tx_last_idx_i`, then wrap back to 0. Each rising edge of `stream_en_i` restarts the order at index 0.
- R5: After a write enable, no further write enable is issued until `slv_ack_i` has been seen high at a clock edge. A word fetched in the meantime is held and delivered at the edge after that acknowledge.
- R6: Each rising edge of `slv_rx_valid_i` while streaming writes `slv_rx_word_i` into the receive RAM at `rx_wptr_o`. The pointer then increments modulo DEPTH (DEPTH is a power of two). Each rising edge of `stream_en_i` resets the pointer to 0.
- R7: A request that arrives while a fetch is in flight (address issued, or word waiting for delivery) is dropped. It sets `fetch_err_o`, which stays set until reset.
- R8: With streaming off, `host_we_i` writes `host_wdata_i` to the RAM chosen by `host_sel_rx_i` (0 = transmit, 1 = receive). `host_rdata_o` shows the selected RAM's word at `host_addr_i` one clock edge later.
- R9: Host writes are ignored while `stream_en_i` is 1.
- R10: `slv_tx_word_o` keeps its last delivered value until the next delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stream_en_i | input | 1 | 1 = streaming, 0 = host access |
| tx_last_idx_i | input | AW | Last transmit RAM index before wrap |
| host_sel_rx_i | input | 1 | Host RAM select: 0 transmit, 1 receive |
| host_addr_i | input | AW | Host word address |
| host_wdata_i | input | W | Host write data |
| host_we_i | input | 1 | Host write enable |
| host_rdata_o | output | W | Host read data, one cycle latency |
| slv_req_i | input | 1 | Lookahead data request from the slave |
| slv_ack_i | input | 1 | Write acknowledge from the slave |
| slv_rx_valid_i | input | 1 | Received-word strobe from the slave |
| slv_rx_word_i | input | W | Received parallel word |
| slv_tx_word_o | output | W | Word offered to the slave |
| slv_tx_we_o | output | 1 | One-cycle write enable to the slave |
| fetch_err_o | output | 1 | Sticky overlap error |
| rx_wptr_o | output | AW | Next receive RAM write index |

## Verification
The bench builds the block with a 16-bit word and RAMs eight deep, and sets the wrap index to 5. Two short streaming runs then reach the transmit wrap from index 5 back to 0, and the receive pointer wrapping past index 7 onto earlier entries. Withholding the acknowledge stalls a fetched word in the pipeline. That stall creates the in-flight overlap behind the error flag, which the slave's two-cycle request pulses could never create alone.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  // Position of the single word that can be in the fetch pipeline.
  typedef enum logic [1:0] {
    STG_IDLE = 2'd0,
    STG_ADDR = 2'd1,
    STG_DATA = 2'd2
  } fetch_stage_e;

endpackage

// File: rtl/seq_rise_det.sv
module seq_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/seq_sync_ram.sv
module seq_sync_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];

  // Read-before-write: the registered read returns the old word.
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/seq_fetch_pipe.sv
module seq_fetch_pipe
  import spi_seq_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          req_rise_i,
  input  logic          ack_i,
  input  logic [AW-1:0] last_idx_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [W-1:0]  rd_data_i,
  output logic [W-1:0]  word_o,
  output logic          we_o,
  output logic          err_o
);

  fetch_stage_e  stage_q, stage_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          wait_q, wait_d;
  logic [W-1:0]  word_q, word_d;
  logic          we_q, we_d;
  logic          err_q, err_d;
  logic          busy, accept, deliver;

  always_comb begin
    busy    = (stage_q != STG_IDLE);
    accept  = req_rise_i & ~busy;
    deliver = en_i & (stage_q == STG_DATA) & ~wait_q;

    stage_d = stage_q;
    if (!en_i) begin
      stage_d = STG_IDLE;
    end else begin
      case (stage_q)
        STG_IDLE: if (accept)  stage_d = STG_ADDR;
        STG_ADDR:              stage_d = STG_DATA;
        STG_DATA: if (deliver) stage_d = STG_IDLE;
        default:               stage_d = STG_IDLE;
      endcase
    end

    ptr_d = ptr_q;
    if (start_i)     ptr_d = '0;
    else if (accept) ptr_d = (ptr_q == last_idx_i) ? '0 : ptr_q + AW'(1);

    addr_d = accept ? ptr_q : addr_q;
    wait_d = en_i & (deliver | (wait_q & ~ack_i));
    we_d   = deliver;
    word_d = deliver ? rd_data_i : word_q;
    err_d  = err_q | (req_rise_i & busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_IDLE;
      ptr_q   <= '0;
      addr_q  <= '0;
      wait_q  <= 1'b0;
      word_q  <= '0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      ptr_q   <= ptr_d;
      addr_q  <= addr_d;
      wait_q  <= wait_d;
      word_q  <= word_d;
      we_q    <= we_d;
      err_q   <= err_d;
    end
  end

  assign rd_addr_o = addr_q;
  assign word_o    = word_q;
  assign we_o      = we_q;
  assign err_o     = err_q;

  assert_we_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);

  assert_ack_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !ack_i) |=> !we_q);

  assert_ptr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !start_i && $stable(last_idx_i)) |=> (ptr_q <= last_idx_i));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  assert_addr_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_q && !deliver) |=> $stable(word_q));

endmodule

// File: rtl/spi_stream_seq.sv
module spi_stream_seq #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stream_en_i,
  input  logic [AW-1:0] tx_last_idx_i,
  input  logic          host_sel_rx_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [W-1:0]  host_wdata_i,
  input  logic          host_we_i,
  output logic [W-1:0]  host_rdata_o,
  input  logic          slv_req_i,
  input  logic          slv_ack_i,
  input  logic          slv_rx_valid_i,
  input  logic [W-1:0]  slv_rx_word_i,
  output logic [W-1:0]  slv_tx_word_o,
  output logic          slv_tx_we_o,
  output logic          fetch_err_o,
  output logic [AW-1:0] rx_wptr_o
);

  logic          en_q, start;
  logic          req_edge, rxv_edge, req_rise, rx_rise;
  logic          host_sel_q;
  logic [AW-1:0] rx_ptr_q, rx_ptr_d;
  logic [AW-1:0] fetch_addr, tx_raddr;
  logic [W-1:0]  tx_rdata, rx_rdata;
  logic          tx_we, rx_we;
  logic [AW-1:0] rx_waddr;
  logic [W-1:0]  rx_wdata;

  seq_rise_det u_req_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(slv_req_i), .rise_o(req_edge));
  seq_rise_det u_rxv_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(slv_rx_valid_i), .rise_o(rxv_edge));

  assign req_rise = req_edge & stream_en_i;
  assign rx_rise  = rxv_edge & stream_en_i;
  assign start    = stream_en_i & ~en_q;

  always_comb begin
    rx_ptr_d = rx_ptr_q;
    if (start)        rx_ptr_d = '0;
    else if (rx_rise) rx_ptr_d = rx_ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      host_sel_q <= 1'b0;
      rx_ptr_q   <= '0;
    end else begin
      en_q       <= stream_en_i;
      host_sel_q <= host_sel_rx_i;
      rx_ptr_q   <= rx_ptr_d;
    end
  end

  // Port steering: streaming owns the fetch read and receive write paths.
  assign tx_we    = host_we_i & ~host_sel_rx_i & ~stream_en_i;
  assign tx_raddr = stream_en_i ? fetch_addr : host_addr_i;
  assign rx_we    = stream_en_i ? rx_rise : (host_we_i & host_sel_rx_i);
  assign rx_waddr = stream_en_i ? rx_ptr_q : host_addr_i;
  assign rx_wdata = stream_en_i ? slv_rx_word_i : host_wdata_i;

  seq_sync_ram #(.W(W), .DEPTH(DEPTH)) u_tx_ram (
    .clk(clk), .we_i(tx_we), .waddr_i(host_addr_i), .wdata_i(host_wdata_i),
    .raddr_i(tx_raddr), .rdata_o(tx_rdata));

  seq_sync_ram #(.W(W), .DEPTH(DEPTH)) u_rx_ram (
    .clk(clk), .we_i(rx_we), .waddr_i(rx_waddr), .wdata_i(rx_wdata),
    .raddr_i(host_addr_i), .rdata_o(rx_rdata));

  seq_fetch_pipe #(.W(W), .DEPTH(DEPTH)) u_fetch (
    .clk(clk), .rst_n(rst_n), .en_i(stream_en_i), .start_i(start),
    .req_rise_i(req_rise), .ack_i(slv_ack_i), .last_idx_i(tx_last_idx_i),
    .rd_addr_o(fetch_addr), .rd_data_i(tx_rdata),
    .word_o(slv_tx_word_o), .we_o(slv_tx_we_o), .err_o(fetch_err_o));

  assign host_rdata_o = host_sel_q ? rx_rdata : tx_rdata;
  assign rx_wptr_o    = rx_ptr_q;

  assert_rx_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rise && !start) |=> (rx_ptr_q == $past(rx_ptr_q) + AW'(1)));

  assert_rx_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_rise && !start) |=> $stable(rx_ptr_q));

  assert_one_fetch_per_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_rise |=> !req_rise);

endmodule

// File: tb/spi_stream_seq_test.sv
module spi_stream_seq_test;

  localparam int W = 16;
  localparam int DEPTH = 8;
  localparam int AW = 3;
  localparam int LAST = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stream_en = 1'b0;
  logic [AW-1:0] tx_last = AW'(LAST);
  logic          hsel = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [W-1:0]  hwdata = '0;
  logic          hwe = 1'b0;
  logic [W-1:0]  hrdata;
  logic          req = 1'b0, ack = 1'b0, rxv = 1'b0;
  logic [W-1:0]  rxw = '0;
  logic [W-1:0]  txw;
  logic          txwe, err;
  logic [AW-1:0] rxptr;
  bit            rd_flag = 1'b0;

  int n_cmp = 0, n_bad = 0, we_cnt = 0;

  always #10 clk = ~clk;

  spi_stream_seq #(.W(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .stream_en_i(stream_en), .tx_last_idx_i(tx_last),
    .host_sel_rx_i(hsel), .host_addr_i(haddr), .host_wdata_i(hwdata),
    .host_we_i(hwe), .host_rdata_o(hrdata), .slv_req_i(req), .slv_ack_i(ack),
    .slv_rx_valid_i(rxv), .slv_rx_word_i(rxw), .slv_tx_word_o(txw),
    .slv_tx_we_o(txwe), .fetch_err_o(err), .rx_wptr_o(rxptr));

  // Behavioural reference model
  int         m_stage, m_addr, m_ptr, m_rxptr;
  bit         m_wait, m_we, m_err, m_reqp, m_rxvp, m_enp, m_rdchk;
  logic [W-1:0] m_word, m_sword, m_rdata;
  logic [W-1:0] txm [DEPTH];
  logic [W-1:0] rxm [DEPTH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage = 0; m_addr = 0; m_ptr = 0; m_rxptr = 0;
      m_wait = 0; m_we = 0; m_err = 0; m_reqp = 0; m_rxvp = 0; m_enp = 0;
      m_rdchk = 0; m_word = '0; m_sword = '0;
    end else begin
      bit rr, rv, st, busy, dlv;
      rr = req && !m_reqp && stream_en;
      rv = rxv && !m_rxvp && stream_en;
      st = stream_en && !m_enp;
      busy = (m_stage != 0);
      dlv = stream_en && m_stage == 2 && !m_wait;
      m_rdata = hsel ? rxm[haddr] : txm[haddr];
      m_rdchk = rd_flag && !stream_en;
      if (dlv) m_word = m_sword;
      m_we = dlv;
      m_wait = stream_en && (dlv || (m_wait && !ack));
      if (rr && busy) m_err = 1;
      if (!stream_en) m_stage = 0;
      else if (m_stage == 0) begin
        if (rr) begin
          m_stage = 1; m_addr = m_ptr;
          m_ptr = (m_ptr == int'(tx_last)) ? 0 : m_ptr + 1;
        end
      end else if (m_stage == 1) begin
        m_stage = 2; m_sword = txm[m_addr];
      end else if (dlv) m_stage = 0;
      if (st) m_ptr = 0;
      if (st) m_rxptr = 0;
      else if (rv) begin rxm[m_rxptr] = rxw; m_rxptr = (m_rxptr + 1) % DEPTH; end
      if (!stream_en && hwe) begin
        if (hsel) rxm[haddr] = hwdata; else txm[haddr] = hwdata;
      end
      m_reqp = req; m_rxvp = rxv; m_enp = stream_en;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison, 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk(txwe === m_we, "R3 write enable", 32'(txwe), 32'(m_we));
      chk(txw === m_word, "R4 delivered word", 32'(txw), 32'(m_word));
      chk(err === m_err, "R7 error flag", 32'(err), 32'(m_err));
      chk(rxptr === AW'(m_rxptr), "R6 receive pointer", 32'(rxptr), 32'(m_rxptr));
      if (m_rdchk) chk(hrdata === m_rdata, "R8 host read", 32'(hrdata), 32'(m_rdata));
      if (txwe === 1'b1) we_cnt++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic req_pulse();
    @(negedge clk) req = 1'b1;
    @(negedge clk);
    @(negedge clk) req = 1'b0;
  endtask
  task automatic ack_pulse();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask
  task automatic rx_pulse(input logic [W-1:0] w);
    @(negedge clk) begin rxv = 1'b1; rxw = w; end
    @(negedge clk);
    @(negedge clk) rxv = 1'b0;
  endtask
  task automatic host_write(input bit s, input int a, input logic [W-1:0] d);
    @(negedge clk) begin hsel = s; haddr = AW'(a); hwdata = d; hwe = 1'b1; end
    @(negedge clk) hwe = 1'b0;
  endtask
  task automatic host_read(input bit s, input int a);
    @(negedge clk) begin hsel = s; haddr = AW'(a); rd_flag = 1'b1; end
    @(negedge clk) rd_flag = 1'b0;
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(txwe === 1'b0 && txw === '0 && err === 1'b0 && rxptr === '0,
        "R1 reset outputs", {txw, 3'b0, rxptr, 4'b0, 2'b0, err, txwe}, 32'h0);
    rst_n = 1'b1;
    idle(1);
    chk(txwe === 1'b0 && txw === '0 && err === 1'b0 && rxptr === '0,
        "R1 after release", 32'(txw), 32'h0);

    for (int i = 0; i < DEPTH; i++) host_write(1'b0, i, W'(16'hA000 + i * 16'h0111));
    for (int i = 0; i < DEPTH; i++) host_write(1'b1, i, 16'h0000);
    host_read(1'b0, 3);
    chk(hrdata === 16'hA333, "R8 tx readback", 32'(hrdata), 32'hA333);
    host_read(1'b1, 6);
    chk(hrdata === 16'h0000, "R8 rx readback", 32'(hrdata), 32'h0);

    // R2: no fetch while disabled
    c0 = we_cnt;
    req_pulse(); idle(5);
    chk(we_cnt == c0, "R2 request while disabled", 32'(we_cnt), 32'(c0));

    @(negedge clk) stream_en = 1'b1;
    idle(2);
    // R9: host write while streaming is ignored
    host_write(1'b0, 0, 16'hDEAD);

    for (int i = 0; i < 8; i++) begin
      c0 = we_cnt;
      req_pulse(); idle(3);
      chk(we_cnt == c0 + 1, "R2 one enable per pulse", 32'(we_cnt), 32'(c0 + 1));
      ack_pulse();
      rx_pulse(W'(16'h5000 + i));
      idle(2);
    end
    // after wrap at index 5: 0..5,0,1 -> last index 1
    chk(txw === 16'hA111, "R4 wrap order", 32'(txw), 32'hA111);
    chk(rxptr === 3'd0, "R6 pointer wrap", 32'(rxptr), 32'h0);

    // R5/R7: withheld acknowledge
    req_pulse(); idle(3);                 // word index 2 delivered, no ack
    c0 = we_cnt;
    req_pulse(); idle(4);                 // index 3 fetched, stalled
    chk(we_cnt == c0, "R5 stall without ack", 32'(we_cnt), 32'(c0));
    chk(txw === 16'hA222, "R10 word held during stall", 32'(txw), 32'hA222);
    req_pulse(); idle(2);                 // overlap
    chk(err === 1'b1, "R7 overlap sets error", 32'(err), 32'h1);
    ack_pulse(); idle(3);
    chk(we_cnt == c0 + 1, "R5 released by ack", 32'(we_cnt), 32'(c0 + 1));
    chk(txw === 16'hA333, "R5 held word delivered", 32'(txw), 32'hA333);
    ack_pulse();
    rx_pulse(16'h6000); rx_pulse(16'h6001); idle(2);
    chk(rxptr === 3'd2, "R6 pointer after more writes", 32'(rxptr), 32'h2);
    idle(6);
    chk(err === 1'b1, "R7 error stays set", 32'(err), 32'h1);
    chk(txw === 16'hA333, "R10 word held while idle", 32'(txw), 32'hA333);

    @(negedge clk) stream_en = 1'b0;
    idle(2);
    host_read(1'b0, 0);
    chk(hrdata === 16'hA000, "R9 streaming write ignored", 32'(hrdata), 32'hA000);
    host_read(1'b1, 0);
    chk(hrdata === 16'h6000, "R6 overwrite after wrap", 32'(hrdata), 32'h6000);
    host_read(1'b1, 5);
    chk(hrdata === 16'h5005, "R8 received word", 32'(hrdata), 32'h5005);

    // re-enable restarts both orders
    @(negedge clk) stream_en = 1'b1;
    idle(2);
    chk(rxptr === 3'd0, "R6 restart on enable", 32'(rxptr), 32'h0);
    req_pulse(); idle(3);
    chk(txw === 16'hA000, "R4 restart at index 0", 32'(txw), 32'hA000);
    ack_pulse(); idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule